// File: doc/BRIEF.md
# Supervisory Reset Timer with Manual Input

This block turns two sources into one system reset. The first source is a digital flag from an analog comparator that says the supply has dropped too low. The second source is a bidirectional open-drain reset pin that a push-button or another chip can pull to its asserted level. Short spikes on either source are filtered out. An accepted cause asserts the reset, and the reset stays asserted for a full timeout after the cause has gone away.

The pin is shared. The block drives the pin while its reset is active, and at the end of the timeout it stops driving so the external pull resistor sets the level. A parameter selects the polarity. In the active-low variant the pin asserts by being pulled low. In the active-high variant it asserts high. The manual input is edge-triggered and is masked while the block itself drives the pin, so the block cannot retrigger itself. The timeout, the supply filter and the manual filter are all counted in clock cycles.

Top module: `supv_reset_timer`

## Requirements
- R1: During `por_n` low, `rst_active` is 1. After `por_n` rises at a clock's falling edge, with the supply flag low, `rst_active` is still 1 at the TIMEOUT_CYC-1th following falling edge and is 0 at the TIMEOUT_CYC-th.
- R2: When `vlow_in` rises and stays high for at least SUP_FILT cycles, `rst_active` becomes 1 at the SUP_FILT+3rd falling edge after the change. It stays 1 while the flag remains high.
- R3: A high pulse on `vlow_in` that lasts fewer than SUP_FILT cycles leaves `rst_active` at 0.
- R4: When `vlow_in` falls, `rst_active` returns to 0 at exactly the TIMEOUT_CYC+3rd falling edge after the change.
- R5: Suppose `mr_pin_in` moves from the idle level to the asserted level (0 when ACTIVE_HIGH=0, 1 when ACTIVE_HIGH=1) and holds for at least MAN_FILT cycles. Then `rst_active` becomes 1 at the MAN_FILT+3rd falling edge after the transition and stays 1 for exactly TIMEOUT_CYC cycles, even if the pulse is much shorter than the timeout.
- R6: An asserted pulse on `mr_pin_in` shorter than MAN_FILT cycles leaves `rst_active` at 0.
- R7: Manual edges are ignored while `rst_active` is 1. A pin level held past the end of the timeout does not start a new reset, and the pin level that the block itself drove does not start a new reset.
- R8: `pin_oe` equals `rst_active`. `rst_level` is 0 while reset is active when ACTIVE_HIGH=0, and 1 while reset is active when ACTIVE_HIGH=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| vlow_in | input | 1 | Comparator flag, 1 = supply below threshold |
| mr_pin_in | input | 1 | Sampled level of the shared reset pin |
| rst_active | output | 1 | 1 while reset is asserted |
| rst_level | output | 1 | Reset expressed in the selected pin polarity |
| pin_oe | output | 1 | Open-drain enable; the driver forces the pin to its asserted level |

## Verification
A timeout counter with the wrong value shows up at `rst_active` as a release edge that is early or late by a fixed number of cycles. It is visible at the first release after the fault. A filter counter that gets stuck lets a short spike through, or blocks a valid cause, and this shows within SUP_FILT or MAN_FILT cycles of the stimulus. A manual edge detector that is left armed through the block's own drive period shows as a second back-to-back timeout right after the release. For that reason the bench compares the outputs with the reference model on every cycle, rather than only at the end of each scenario.

// File: rtl/supv_reset_timer.sv
module supv_reset_timer #(
  parameter int unsigned TIMEOUT_CYC = 50_000_000,
  parameter int unsigned SUP_FILT    = 8,
  parameter int unsigned MAN_FILT    = 26,
  parameter bit          ACTIVE_HIGH = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic vlow_in,
  input  logic mr_pin_in,
  output logic rst_active,
  output logic rst_level,
  output logic pin_oe
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int SW = $clog2(SUP_FILT + 1);
  localparam int MW = $clog2(MAN_FILT + 1);
  localparam logic ASSERT_LVL = ACTIVE_HIGH;
  localparam logic IDLE_LVL   = ~ACTIVE_HIGH;

  logic [1:0]    vlow_sync, pin_sync;
  logic [SW-1:0] sup_cnt;
  logic [MW-1:0] man_cnt;
  logic [TW-1:0] tmr;
  logic          vlow_s, sup_low;
  logic          pin_act, pin_act_q, man_edge, armed, man_fire;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      vlow_sync <= 2'b00;
      pin_sync  <= {2{IDLE_LVL}};
    end else begin
      vlow_sync <= {vlow_sync[0], vlow_in};
      pin_sync  <= {pin_sync[0], mr_pin_in};
    end

  assign vlow_s  = vlow_sync[1];
  assign sup_low = (sup_cnt == SW'(SUP_FILT));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)       sup_cnt <= '0;
    else if (!vlow_s) sup_cnt <= '0;
    else if (!sup_low) sup_cnt <= sup_cnt + 1'b1;

  assign pin_act  = (pin_sync[1] == ASSERT_LVL);
  assign man_edge = pin_act & ~pin_act_q;
  assign man_fire = armed & (man_cnt == MW'(MAN_FILT)) & ~rst_active;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pin_act_q <= 1'b1;
      armed     <= 1'b0;
      man_cnt   <= '0;
    end else begin
      pin_act_q <= pin_act;
      if (rst_active || man_fire) begin
        armed   <= 1'b0;
        man_cnt <= '0;
      end else if (man_edge) begin
        armed   <= 1'b1;
        man_cnt <= MW'(1);
      end else if (armed) begin
        if (!pin_act) begin
          armed   <= 1'b0;
          man_cnt <= '0;
        end else if (man_cnt != MW'(MAN_FILT)) begin
          man_cnt <= man_cnt + 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                  tmr <= TW'(TIMEOUT_CYC);
    else if (sup_low || man_fire) tmr <= TW'(TIMEOUT_CYC);
    else if (tmr != '0)          tmr <= tmr - 1'b1;

  assign rst_active = (tmr != '0);
  assign pin_oe     = rst_active;
  assign rst_level  = ACTIVE_HIGH ? rst_active : ~rst_active;

endmodule

module supv_reset_timer_chk (
  input logic clk,
  input logic por_n,
  input logic vlow_s,
  input logic sup_low,
  input logic man_fire,
  input logic armed,
  input logic rst_active
);

  // R2
  sup_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    sup_low |=> rst_active);

  // R3
  dip_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    !vlow_s |=> !sup_low);

  // R4
  release_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_active) |-> $past(!sup_low && !man_fire));

  // R5
  man_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    man_fire |=> rst_active);

  // R7
  mask_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_active |=> !armed);

endmodule

bind supv_reset_timer supv_reset_timer_chk chk (
  .clk(clk), .por_n(por_n), .vlow_s(vlow_s), .sup_low(sup_low),
  .man_fire(man_fire), .armed(armed), .rst_active(rst_active)
);

// File: tb/supv_reset_timer_test.sv
module supv_reset_timer_test;
  localparam int TO = 40;
  localparam int SF = 4;
  localparam int MF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vlow = 1'b0;
  logic ext = 1'b0;
  logic oe_q = 1'b1, oeh_q = 1'b1;
  logic rst_l, lvl_l, oe_l, rst_h, lvl_h, oe_h;
  logic pin_l, pin_h;
  int nchk = 0, nfail = 0, cyc = 0, got;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign pin_l = (ext | oe_q)  ? 1'b0 : 1'b1;
  assign pin_h = (ext | oeh_q) ? 1'b1 : 1'b0;

  supv_reset_timer #(.TIMEOUT_CYC(TO), .SUP_FILT(SF), .MAN_FILT(MF), .ACTIVE_HIGH(1'b0)) uut (
    .clk(clk), .por_n(rst_n), .vlow_in(vlow), .mr_pin_in(pin_l),
    .rst_active(rst_l), .rst_level(lvl_l), .pin_oe(oe_l));

  supv_reset_timer #(.TIMEOUT_CYC(TO), .SUP_FILT(SF), .MAN_FILT(MF), .ACTIVE_HIGH(1'b1)) uut_h (
    .clk(clk), .por_n(rst_n), .vlow_in(vlow), .mr_pin_in(pin_h),
    .rst_active(rst_h), .rst_level(lvl_h), .pin_oe(oe_h));

  always @(negedge clk) begin
    oe_q  <= oe_l;
    oeh_q <= oe_h;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int hold, runb, mrun;
  bit b1, b2, p1, p2, prevas, armd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold = TO; runb = 0; mrun = 0;
      b1 = 0; b2 = 0; p1 = 1; p2 = 1; prevas = 1; armd = 0;
    end else begin
      bit sup, act, pas, fire;
      sup  = (runb >= SF);
      act  = (hold > 0);
      pas  = (p2 == 1'b0);
      fire = armd && (mrun >= MF) && !act;
      if (sup || fire) hold = TO;
      else if (hold > 0) hold = hold - 1;
      if (b2) begin if (runb < SF) runb = runb + 1; end
      else runb = 0;
      if (act || fire) begin armd = 0; mrun = 0; end
      else if (pas && !prevas) begin armd = 1; mrun = 1; end
      else if (armd) begin
        if (!pas) begin armd = 0; mrun = 0; end
        else if (mrun < MF) mrun = mrun + 1;
      end
      prevas = pas;
      b2 = b1; b1 = vlow;
      p2 = p1; p1 = pin_l;
    end
  end

  // R8 per-cycle comparison against the model, both polarities
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e;
      e = (hold > 0);
      chk({rst_l, oe_l, lvl_l, rst_h, oe_h, lvl_h} == {e, e, ~e, e, e, e},
          "R8/model", {rst_l, oe_l, lvl_l, rst_h, oe_h, lvl_h}, {e, e, ~e, e, e, e});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    chk(rst_l == 1'b1, "R1 during por", rst_l, 1);
    chk(lvl_l == 1'b0 && lvl_h == 1'b1, "R8 levels in reset", {lvl_l, lvl_h}, 2'b01);
    rst_n = 1'b1;
    wait_n(TO - 1);
    chk(rst_l == 1'b1, "R1 before timeout", rst_l, 1);
    wait_n(1);
    chk(rst_l == 1'b0, "R1 at timeout", rst_l, 0);
    chk(oe_l == 1'b0 && lvl_l == 1'b1 && lvl_h == 1'b0, "R8 released", {oe_l, lvl_l, lvl_h}, 3'b010);
    wait_n(5);

    // R3 short supply dip
    vlow = 1'b1; wait_n(SF - 1); vlow = 1'b0;
    wait_n(12);
    chk(rst_l == 1'b0, "R3 dip ignored", rst_l, 0);

    // R2 supply low latency
    vlow = 1'b1; got = 0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (rst_l) begin got = k; break; end
    end
    chk(got == SF + 3, "R2 assert latency", got, SF + 3);
    wait_n(10);
    chk(rst_l == 1'b1, "R2 held while low", rst_l, 1);

    // R4 release after timeout
    vlow = 1'b0; got = 0;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (!rst_l) begin got = k; break; end
    end
    chk(got == TO + 3, "R4 release delay", got, TO + 3);
    wait_n(8);

    // R6 short manual pulse
    ext = 1'b1; wait_n(MF - 1); ext = 1'b0;
    wait_n(15);
    chk(rst_l == 1'b0, "R6 short manual ignored", rst_l, 0);

    // R5 minimal accepted manual pulse
    ext = 1'b1; got = 0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (k == MF) ext = 1'b0;
      if (rst_l) begin got = k; break; end
    end
    chk(got == MF + 3, "R5 manual latency", got, MF + 3);
    got = 1;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (!rst_l) break;
      got++;
    end
    chk(got == TO, "R5 full timeout", got, TO);
    wait_n(12);
    chk(rst_l == 1'b0, "R7 no self retrigger", rst_l, 0);

    // R7 manual held past timeout
    ext = 1'b1;
    wait_n(MF + 3 + TO + 5);
    chk(rst_l == 1'b0, "R7 held level no retrigger", rst_l, 0);
    wait_n(20); ext = 1'b0;
    wait_n(10);
    chk(rst_l == 1'b0, "R7 after held release", rst_l, 0);

    // R7 manual edge during countdown is masked
    vlow = 1'b1; wait_n(20);
    vlow = 1'b0; got = 0;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (k == 5) ext = 1'b1;
      if (k == 15) ext = 1'b0;
      if (!rst_l) begin got = k; break; end
    end
    chk(got == TO + 3, "R7 masked during drive", got, TO + 3);
    wait_n(15);
    chk(rst_l == 1'b0, "R7 stays released", rst_l, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule